// File: doc/BRIEF.md
# Output Stage Power-On Switch Sequencer

This block controls the six analog switches around a DAC output amplifier during power-up and while the output is cleared. It starts with the amplifier wired as a unity-gain buffer and the output pin tied through a resistor to the ground-sense node. It moves the amplifier into its gain configuration only after a supply-adequate flag has been held for a programmable number of clocks. The amplifier's non-inverting input is connected either to the DAC or to the ground-sense node, depending on the active-low clear input. The two input switches never conduct together: every change between them passes through one cycle in which both are open.

The external supply comparators give the block the flag `supply_ok`. The clear line `clr_n` arrives already synchronous to `clk`. The six outputs drive the switch gates directly, with 1 meaning closed. They come straight from flops or through a single inverter, so no decode logic sits between the state and the gates.

Top module: `outstage_sequencer`

## Requirements
- R1: While `rst` is high, each clock edge sets the stage to pre-supply. The same edge selects the ground-sense input (`sel_sense`=1, `sel_dac`=0) if `clr_n` is 0, or the DAC input (`sel_dac`=1, `sel_sense`=0) if `clr_n` is 1.
- R2: In the pre-supply stage, `fb_unity`=1, `out_tie`=1, `fb_gain`=0 and `gain_leg`=0.
- R3: The stage advances from pre-supply to run on the clock edge that samples `supply_ok`=1 for the DEB_CYCLES-th consecutive time. Any edge that samples `supply_ok`=0 restarts the count.
- R4: In the run stage, `fb_unity`=0, `out_tie`=0, `fb_gain`=1 and `gain_leg`=1. The unity pair and the gain pair always carry opposite values.
- R5: In the run stage, an edge that samples `supply_ok`=0 returns the block to the pre-supply stage, and the debounce count restarts from zero.
- R6: `sel_dac` and `sel_sense` are never both 1.
- R7: Suppose an edge samples `clr_n` differing from the closed input, where `clr_n`=1 wants the DAC and `clr_n`=0 wants ground-sense. After that edge both input switches are open for exactly one cycle. The following edge then closes the input that `clr_n` selects at that edge.
- R8: Input selection works the same way in both stages and does not depend on the stage. A stage change and an input change on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply headroom adequate flag from external comparators |
| clr_n | input | 1 | Active-low clear; 1 selects the DAC input, 0 the ground-sense input |
| sel_dac | output | 1 | Close switch from DAC to amplifier input |
| sel_sense | output | 1 | Close switch from ground-sense node to amplifier input |
| fb_unity | output | 1 | Close unity-gain feedback switch |
| fb_gain | output | 1 | Close gain-of-two feedback switch |
| gain_leg | output | 1 | Close gain-network return leg to ground-sense |
| out_tie | output | 1 | Close resistor tie from output pin to ground-sense |

## Verification
The debounce-driven stage change and the clear-driven input reselection can land on the same clock edge. The bench provokes this in two ways. It flips `clr_n` on the very edge that completes the debounce count, and it drops `supply_ok` on the same edge that `clr_n` falls during run. A behavioural model with separate stage and selection state predicts every cycle. Both the feedback pair and the break-before-make gap must match the model on that edge and the one after it, and an exclusivity check guards the input pair throughout.

// File: rtl/outstage_pkg.sv
package outstage_pkg;

    typedef enum logic {
        ST_PRE = 1'b0,
        ST_RUN = 1'b1
    } stage_e;

    // one bit per input switch, so each gate is a flop output
    typedef enum logic [1:0] {
        IN_GAP   = 2'b00,
        IN_SENSE = 2'b01,
        IN_DAC   = 2'b10
    } insel_e;

    typedef struct packed {
        logic sel_dac;
        logic sel_sense;
        logic fb_unity;
        logic fb_gain;
        logic gain_leg;
        logic out_tie;
    } sw_t;

    function automatic insel_e wanted_input(input logic clr_n);
        return clr_n ? IN_DAC : IN_SENSE;
    endfunction

    function automatic sw_t sw_decode(input stage_e st, input insel_e s);
        sw_t r;
        r.sel_dac   = s[1];
        r.sel_sense = s[0];
        r.fb_gain   = st;
        r.gain_leg  = st;
        r.fb_unity  = ~st;
        r.out_tie   = ~st;
        return r;
    endfunction

endpackage

// File: rtl/outstage_debounce.sv
module outstage_debounce
    import outstage_pkg::*;
#(
    parameter int DEB_CYCLES = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   supply_ok,
    output stage_e stage
);

    localparam int CW = $clog2(DEB_CYCLES + 1);

    generate
        if (DEB_CYCLES <= 1) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst || !supply_ok) begin
                    stage <= ST_PRE;
                end else begin
                    stage <= ST_RUN;
                end
            end
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !supply_ok) begin
                    stage <= ST_PRE;
                    cnt   <= '0;
                end else if (stage == ST_PRE) begin
                    if (cnt == LAST) begin
                        stage <= ST_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/outstage_insel.sv
module outstage_insel
    import outstage_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_n,
    output insel_e sel
);

    insel_e want;
    assign want = wanted_input(clr_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= want;
        end else begin
            case (sel)
                IN_GAP:   sel <= want;
                IN_SENSE: if (want != IN_SENSE) sel <= IN_GAP;
                IN_DAC:   if (want != IN_DAC)   sel <= IN_GAP;
                default:  sel <= IN_GAP;
            endcase
        end
    end

endmodule

// File: rtl/outstage_sequencer.sv
module outstage_sequencer
    import outstage_pkg::*;
#(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic clr_n,
    output logic sel_dac,
    output logic sel_sense,
    output logic fb_unity,
    output logic fb_gain,
    output logic gain_leg,
    output logic out_tie
);

    stage_e stage;
    insel_e sel;
    sw_t    sw;

    outstage_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .stage     (stage)
    );

    outstage_insel u_sel (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .sel   (sel)
    );

    assign sw = sw_decode(stage, sel);

    assign sel_dac   = sw.sel_dac;
    assign sel_sense = sw.sel_sense;
    assign fb_unity  = sw.fb_unity;
    assign fb_gain   = sw.fb_gain;
    assign gain_leg  = sw.gain_leg;
    assign out_tie   = sw.out_tie;

endmodule

// File: rtl/outstage_sequencer_chk.sv
module outstage_sequencer_chk #(
    parameter int DEB_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic clr_n,
    input logic sel_dac,
    input logic sel_sense,
    input logic fb_unity,
    input logic fb_gain,
    input logic gain_leg,
    input logic out_tie
);

    localparam int CW = $clog2(DEB_CYCLES + 2);
    localparam logic [CW-1:0] SAT = CW'(DEB_CYCLES + 1);
    localparam logic [CW-1:0] DEB = CW'(DEB_CYCLES);

    logic [CW-1:0] ok_run;
    logic          rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || !supply_ok) begin
            ok_run <= '0;
        end else if (ok_run != SAT) begin
            ok_run <= ok_run + 1'b1;
        end
    end

    assert_no_short_R6: assert property (@(posedge clk) disable iff (rst || rst_d)
        !(sel_dac && sel_sense));

    assert_fb_pairs_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
        (fb_gain == gain_leg) && (fb_unity == out_tie) && (fb_unity != fb_gain));

    assert_debounce_R3: assert property (@(posedge clk) disable iff (rst || rst_d)
        $rose(fb_gain) |-> (ok_run == DEB));

    assert_supply_loss_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
        (fb_gain && !supply_ok) |=> (fb_unity && out_tie));

    assert_gap_before_dac_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
        (sel_dac && !$past(sel_dac)) |-> !$past(sel_sense));

    assert_gap_before_sense_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
        (sel_sense && !$past(sel_sense)) |-> !$past(sel_dac));

    assert_gap_one_cycle_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
        (!sel_dac && !sel_sense) |=> (sel_dac || sel_sense));

    assert_release_opens_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
        (sel_sense && clr_n) |=> !sel_sense);

endmodule

bind outstage_sequencer outstage_sequencer_chk #(.DEB_CYCLES(DEB_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .clr_n     (clr_n),
    .sel_dac   (sel_dac),
    .sel_sense (sel_sense),
    .fb_unity  (fb_unity),
    .fb_gain   (fb_gain),
    .gain_leg  (gain_leg),
    .out_tie   (out_tie)
);

// File: tb/outstage_sequencer_tb.sv
module outstage_sequencer_tb;

    localparam int DEB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic clr_n = 1'b0;
    logic sel_dac, sel_sense, fb_unity, fb_gain, gain_leg, out_tie;

    int vectors = 0;
    int fails = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural reference: stage 0 pre / 1 run; sel 0 sense / 1 dac / 2 gap
    int m_stage = 0;
    int m_cnt = 0;
    int m_sel = 0;

    always #5 clk = ~clk;

    outstage_sequencer #(.DEB_CYCLES(DEB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .clr_n     (clr_n),
        .sel_dac   (sel_dac),
        .sel_sense (sel_sense),
        .fb_unity  (fb_unity),
        .fb_gain   (fb_gain),
        .gain_leg  (gain_leg),
        .out_tie   (out_tie)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0;
            m_cnt = 0;
            m_sel = clr_n ? 1 : 0;
        end else begin
            if (m_sel == 2) m_sel = clr_n ? 1 : 0;
            else if (m_sel != (clr_n ? 1 : 0)) m_sel = 2;
            if (!supply_ok) begin
                m_stage = 0;
                m_cnt = 0;
            end else if (m_stage == 0) begin
                m_cnt++;
                if (m_cnt == DEB) begin
                    m_stage = 1;
                    m_cnt = 0;
                end
            end
        end
    end

    task automatic cmp(input string req, input string name, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b exp %b at %0t", req, name, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !done) begin
            string fr;
            fr = (m_stage == 1) ? "R4" : "R2";
            cmp(tag, "sel_dac", sel_dac, m_sel == 1);
            cmp(tag, "sel_sense", sel_sense, m_sel == 0);
            cmp(fr, "fb_unity", fb_unity, m_stage == 0);
            cmp(fr, "out_tie", out_tie, m_stage == 0);
            cmp(fr, "fb_gain", fb_gain, m_stage == 1);
            cmp(fr, "gain_leg", gain_leg, m_stage == 1);
            cmp("R6", "input pair exclusive", sel_dac && sel_sense, 1'b0);
        end
    end

    task automatic drive(input logic ok, input logic c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            supply_ok = ok;
            clr_n = c;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        checking = 1'b1;
        // R1: reset picks the input that matches clr_n
        tag = "R1";
        drive(1'b0, 1'b0, 3);
        drive(1'b0, 1'b1, 3);
        @(negedge clk);
        rst = 1'b0;
        // R3: debounce with interrupted runs, then a full run
        tag = "R3";
        drive(1'b1, 1'b1, 2);
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, 3);
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, DEB + 3);
        // R7: clear toggles in run, slow and every cycle
        tag = "R7";
        drive(1'b1, 1'b0, 3);
        drive(1'b1, 1'b1, 3);
        for (int i = 0; i < 6; i++) drive(1'b1, i[0], 1);
        drive(1'b1, 1'b1, 3);
        // R5: supply loss in run with clear steady
        tag = "R5";
        drive(1'b0, 1'b1, 2);
        drive(1'b1, 1'b1, DEB + 2);
        // R8: supply loss and clear on the same edge
        tag = "R8";
        drive(1'b0, 1'b0, 3);
        // R8: clear released on the edge that completes the debounce
        drive(1'b1, 1'b0, DEB - 1);
        drive(1'b1, 1'b1, 4);
        // R8: clear toggles during pre-supply
        drive(1'b0, 1'b0, 3);
        drive(1'b0, 1'b1, 3);
        // R1: reset from run
        tag = "R1";
        drive(1'b1, 1'b0, DEB + 2);
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 1'b0, 2);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 3);
        finish_run();
    end

endmodule